// File: doc/BRIEF.md
# Program Sequencer with Return-Address Stack

This block decides which instruction address a small controller fetches next. Each cycle in which the advance strobe is high, it looks at the current instruction word and the carry and zero flags. It then either moves the program counter on by one, or loads a branch target, or loads a saved return address. The program counter drives the address input of an external instruction memory.

Subroutine calls save the address that follows the call on a hardware return stack, and returns take that address back. The stack pointer simply wraps when the stack runs too deep or is popped while empty, and no error is raised. Flag-conditional forms of jump, call and return read a two-bit condition field just below the opcode. The flags come from outside the block.

Top module: `pcseq_top`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, empties the return stack (pointer 0) and clears every stack entry to 0.
- R2: While `step` is low, the program counter and the stack keep their values whatever the instruction is.
- R3: An instruction that is not a taken jump, call or return advances the program counter by one, and 1023 wraps to 0.
- R4: Opcode 110100 (instruction bits 17:12) is an unconditional jump that loads bits 9:0 of the instruction into the program counter.
- R5: Opcodes 110101, 110001 and 101011 are the conditional jump, call and return forms. Bits 11:10 select the condition: 00 zero flag set, 01 zero flag clear, 10 carry flag set, 11 carry flag clear. A false condition acts as R3.
- R6: Opcode 110000, or a taken 110001, pushes the program counter plus one (wrapping) onto the stack and loads bits 9:0 as the new program counter, both in the same cycle.
- R7: Opcode 101010, or a taken 101011, loads the newest stack entry into the program counter and pops it, so that nested calls return in last-in first-out order.
- R8: The stack holds 32 entries and its pointer wraps modulo 32. A 33rd nested push overwrites the oldest entry, and a pop from an empty stack reads entry 0 and moves the pointer to the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance strobe: the instruction is executed this cycle |
| instr | input | 18 | Current instruction word |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| pc | output | 10 | Program counter, the fetch address |

## Verification
A call writes the return stack and redirects the program counter on the same clock edge. The value it writes is the incremented counter, so a call placed at address 1023 must push 0 while it also jumps. The bench provokes this by jumping to 1023 and calling from there, and it judges the result through the return that follows, which must land on 0. Wrap in both directions is provoked by popping an empty stack and then pushing 33 nested calls. A software model of the stack predicts every return address.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

   localparam int OPC_W  = 6;
   localparam int COND_W = 2;

   // opcode with its lowest bit dropped; that bit marks the conditional form
   localparam logic [OPC_W-2:0] GRP_JUMP = 5'b11010;
   localparam logic [OPC_W-2:0] GRP_CALL = 5'b11000;
   localparam logic [OPC_W-2:0] GRP_RET  = 5'b10101;

   typedef enum logic [COND_W-1:0] {
      COND_ZSET = 2'b00,
      COND_ZCLR = 2'b01,
      COND_CSET = 2'b10,
      COND_CCLR = 2'b11
   } cond_e;

   typedef struct packed {
      logic jump;
      logic call;
      logic ret;
   } flow_t;

   function automatic logic cond_met(input cond_e sel, input logic c, input logic z);
      case (sel)
         COND_ZSET: return z;
         COND_ZCLR: return !z;
         COND_CSET: return c;
         default:   return !c;
      endcase
   endfunction

endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
   import pcseq_pkg::*;
#(
   parameter int INSTR_W = 18,
   parameter int PC_W    = 10
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic               flag_c,
   input  logic               flag_z,
   output flow_t              go,
   output logic [PC_W-1:0]    target
);

   localparam int OPC_LSB  = INSTR_W - OPC_W;
   localparam int COND_LSB = OPC_LSB - COND_W;

   logic [OPC_W-1:0]  opcode;
   logic [OPC_W-2:0]  group;
   logic              is_cond;
   cond_e             cond_sel;
   logic              cond_ok;

   assign opcode   = instr[INSTR_W-1 -: OPC_W];
   assign group    = opcode[OPC_W-1:1];
   assign is_cond  = opcode[0];
   assign cond_sel = cond_e'(instr[COND_LSB +: COND_W]);
   assign cond_ok  = !is_cond || cond_met(cond_sel, flag_c, flag_z);
   assign target   = instr[PC_W-1:0];

   always_comb begin
      go      = '0;
      go.jump = (group == GRP_JUMP) && cond_ok;
      go.call = (group == GRP_CALL) && cond_ok;
      go.ret  = (group == GRP_RET)  && cond_ok;
   end

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
   parameter int PC_W           = 10,
   parameter int SP_W           = 5,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            push,
   input  logic            pop,
   input  logic [PC_W-1:0] push_val,
   output logic [PC_W-1:0] top,
   output logic [SP_W-1:0] sp
);

   localparam int DEPTH = 1 << SP_W;

   logic [SP_W-1:0] sp_q;
   logic [SP_W-1:0] sp_up;
   logic [SP_W-1:0] sp_dn;
   logic [PC_W-1:0] slot [DEPTH];

   assign sp_up = sp_q + 1'b1;
   assign sp_dn = sp_q - 1'b1;

   always_ff @(posedge clk) begin
      if (rst)       sp_q <= '0;
      else if (push) sp_q <= sp_up;
      else if (pop)  sp_q <= sp_dn;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic            hit;
      logic [PC_W-1:0] q;

      assign hit = push && (sp_up == SP_W'(i));

      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (rst)      q <= '0;
            else if (hit) q <= push_val;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit) q <= push_val;
         end
      end

      assign slot[i] = q;
   end

   assign top = slot[sp_q];
   assign sp  = sp_q;

endmodule

// File: rtl/pcseq_pc.sv
module pcseq_pc
   import pcseq_pkg::*;
#(
   parameter int PC_W = 10
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            advance,
   input  flow_t           go,
   input  logic [PC_W-1:0] target,
   input  logic [PC_W-1:0] ret_addr,
   output logic [PC_W-1:0] pc,
   output logic [PC_W-1:0] pc_inc
);

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_nxt;

   assign pc_inc = pc_q + 1'b1;

   always_comb begin
      if (go.ret)                 pc_nxt = ret_addr;
      else if (go.jump || go.call) pc_nxt = target;
      else                        pc_nxt = pc_inc;
   end

   always_ff @(posedge clk) begin
      if (rst)          pc_q <= '0;
      else if (advance) pc_q <= pc_nxt;
   end

   assign pc = pc_q;

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
   import pcseq_pkg::*;
#(
   parameter int INSTR_W     = 18,
   parameter int PC_W        = 10,
   parameter int SP_W        = 5,
   parameter bit CLEAR_STACK = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               step,
   input  logic [INSTR_W-1:0] instr,
   input  logic               flag_c,
   input  logic               flag_z,
   output logic [PC_W-1:0]    pc
);

   if (INSTR_W < OPC_W + COND_W + PC_W) begin : g_bad_instr_w
      $error("pcseq_top: INSTR_W too small for opcode, condition and target");
   end
   if (PC_W < 2) begin : g_bad_pc_w
      $error("pcseq_top: PC_W must be at least 2");
   end
   if (SP_W < 1 || SP_W > 8) begin : g_bad_sp_w
      $error("pcseq_top: SP_W must lie between 1 and 8");
   end

   flow_t           flow;
   logic [PC_W-1:0] branch_target;
   logic [PC_W-1:0] stack_top;
   logic [PC_W-1:0] pc_inc;
   logic [SP_W-1:0] sp_q;
   logic            go_jump;
   logic            go_call;
   logic            go_ret;

   pcseq_decode #(
      .INSTR_W (INSTR_W),
      .PC_W    (PC_W)
   ) u_decode (
      .instr  (instr),
      .flag_c (flag_c),
      .flag_z (flag_z),
      .go     (flow),
      .target (branch_target)
   );

   assign go_jump = flow.jump;
   assign go_call = flow.call;
   assign go_ret  = flow.ret;

   pcseq_stack #(
      .PC_W           (PC_W),
      .SP_W           (SP_W),
      .CLEAR_ON_RESET (CLEAR_STACK)
   ) u_stack (
      .clk      (clk),
      .rst      (rst),
      .push     (step && go_call),
      .pop      (step && go_ret),
      .push_val (pc_inc),
      .top      (stack_top),
      .sp       (sp_q)
   );

   pcseq_pc #(
      .PC_W (PC_W)
   ) u_pc (
      .clk      (clk),
      .rst      (rst),
      .advance  (step),
      .go       (flow),
      .target   (branch_target),
      .ret_addr (stack_top),
      .pc       (pc),
      .pc_inc   (pc_inc)
   );

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
   parameter int PC_W = 10,
   parameter int SP_W = 5
) (
   input logic            clk,
   input logic            rst,
   input logic            step,
   input logic [PC_W-1:0] pc,
   input logic [SP_W-1:0] sp,
   input logic [PC_W-1:0] top,
   input logic [PC_W-1:0] target,
   input logic            jump_go,
   input logic            call_go,
   input logic            ret_go
);

   assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !step |=> ($stable(pc) && $stable(sp) && $stable(top)));

   assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
      (step && !jump_go && !call_go && !ret_go) |=> (pc == PC_W'($past(pc) + 1'b1)));

   assert_jump_R4: assert property (@(posedge clk) disable iff (rst)
      (step && jump_go) |=> (pc == $past(target) && sp == $past(sp)));

   assert_single_flow_R5: assert property (@(posedge clk) disable iff (rst)
      $onehot0({jump_go, call_go, ret_go}));

   assert_call_push_R6: assert property (@(posedge clk) disable iff (rst)
      (step && call_go) |=> (pc == $past(target) && top == PC_W'($past(pc) + 1'b1)));

   assert_return_pop_R7: assert property (@(posedge clk) disable iff (rst)
      (step && ret_go) |=> (pc == $past(top)));

   assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (rst)
      (step && (call_go || ret_go)) |=>
         (sp == ($past(call_go) ? SP_W'($past(sp) + 1'b1) : SP_W'($past(sp) - 1'b1))));

endmodule

bind pcseq_top pcseq_checker #(
   .PC_W (PC_W),
   .SP_W (SP_W)
) u_pcseq_chk (
   .clk     (clk),
   .rst     (rst),
   .step    (step),
   .pc      (pc),
   .sp      (sp_q),
   .top     (stack_top),
   .target  (branch_target),
   .jump_go (go_jump),
   .call_go (go_call),
   .ret_go  (go_ret)
);

// File: tb/test_pcseq_top.sv
module test_pcseq_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        step;
   logic [17:0] instr;
   logic        flag_c;
   logic        flag_z;
   logic [9:0]  pc;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = !clk;

   pcseq_top i_pcseq_top (
      .clk    (clk),
      .rst    (rst),
      .step   (step),
      .instr  (instr),
      .flag_c (flag_c),
      .flag_z (flag_z),
      .pc     (pc)
   );

   // vector: [34:31] requirement, [30:13] instruction, [12] carry, [11] zero, [10] step, [9:0] expected pc
   localparam int NVEC = 24;
   localparam logic [34:0] VEC [NVEC] = '{
      {4'd3, 18'h00000, 1'b0, 1'b0, 1'b1, 10'h001},  // R3 plain advance
      {4'd2, 18'h00000, 1'b0, 1'b0, 1'b0, 10'h001},  // R2 no step
      {4'd4, 18'h343FE, 1'b0, 1'b0, 1'b1, 10'h3FE},  // R4 jump
      {4'd3, 18'h01234, 1'b1, 1'b1, 1'b1, 10'h3FF},  // R3
      {4'd3, 18'h00000, 1'b0, 1'b0, 1'b1, 10'h000},  // R3 wrap 1023 -> 0
      {4'd5, 18'h35055, 1'b0, 1'b0, 1'b1, 10'h001},  // R5 zero-set false
      {4'd5, 18'h35055, 1'b0, 1'b1, 1'b1, 10'h055},  // R5 zero-set true
      {4'd5, 18'h354AA, 1'b0, 1'b1, 1'b1, 10'h056},  // R5 zero-clear false
      {4'd5, 18'h354AA, 1'b0, 1'b0, 1'b1, 10'h0AA},  // R5 zero-clear true
      {4'd5, 18'h35923, 1'b0, 1'b0, 1'b1, 10'h0AB},  // R5 carry-set false
      {4'd5, 18'h35923, 1'b1, 1'b0, 1'b1, 10'h123},  // R5 carry-set true
      {4'd5, 18'h35E00, 1'b1, 1'b0, 1'b1, 10'h124},  // R5 carry-clear false
      {4'd5, 18'h35E00, 1'b0, 1'b0, 1'b1, 10'h200},  // R5 carry-clear true
      {4'd6, 18'h30300, 1'b0, 1'b0, 1'b1, 10'h300},  // R6 call, pushes 0x201
      {4'd5, 18'h31310, 1'b0, 1'b0, 1'b1, 10'h301},  // R5 conditional call false
      {4'd6, 18'h31310, 1'b0, 1'b1, 1'b1, 10'h310},  // R6 conditional call, pushes 0x302
      {4'd2, 18'h30050, 1'b0, 1'b0, 1'b0, 10'h310},  // R2 call without step
      {4'd5, 18'h2B800, 1'b0, 1'b0, 1'b1, 10'h311},  // R5 conditional return false
      {4'd7, 18'h2A000, 1'b0, 1'b0, 1'b1, 10'h302},  // R7 return
      {4'd7, 18'h2B400, 1'b0, 1'b0, 1'b1, 10'h201},  // R7 conditional return true
      {4'd4, 18'h343FF, 1'b0, 1'b0, 1'b1, 10'h3FF},  // R4 jump to last address
      {4'd6, 18'h30010, 1'b0, 1'b0, 1'b1, 10'h010},  // R6 call at 1023 pushes 0
      {4'd3, 18'h00000, 1'b0, 1'b0, 1'b1, 10'h011},  // R3
      {4'd7, 18'h2A000, 1'b0, 1'b0, 1'b1, 10'h000}   // R7 return lands on 0
   };

   // reference model for the directed part
   logic [9:0] m_pc;
   int         m_sp;
   logic [9:0] m_stk [32];

   function automatic logic cond_true(input logic [1:0] sel, input logic c, input logic z);
      case (sel)
         2'b00:   return z;
         2'b01:   return !z;
         2'b10:   return c;
         default: return !c;
      endcase
   endfunction

   task automatic model_reset();
      m_pc = '0;
      m_sp = 0;
      for (int i = 0; i < 32; i++) m_stk[i] = '0;
   endtask

   task automatic model_step(input logic [17:0] ins, input logic c, input logic z);
      logic [4:0] grp;
      logic       ok;
      logic [9:0] nxt;
      grp = ins[17:13];
      ok  = !ins[12] || cond_true(ins[11:10], c, z);
      nxt = m_pc + 10'd1;
      if (grp == 5'b11010 && ok) begin
         m_pc = ins[9:0];
      end else if (grp == 5'b11000 && ok) begin
         m_sp = (m_sp + 1) % 32;
         m_stk[m_sp] = nxt;
         m_pc = ins[9:0];
      end else if (grp == 5'b10101 && ok) begin
         m_pc = m_stk[m_sp];
         m_sp = (m_sp + 31) % 32;
      end else begin
         m_pc = nxt;
      end
   endtask

   task automatic check_pc(input logic [9:0] exp, input string tag);
      n_chk++;
      if (pc !== exp) begin
         n_bad++;
         $display("FAIL %s: pc=%h expected=%h", tag, pc, exp);
      end
   endtask

   // called at a falling edge; applies one cycle and checks at the next falling edge
   task automatic apply(input logic [17:0] ins, input logic c, input logic z,
                        input logic s, input logic [9:0] exp, input string tag);
      instr  = ins;
      flag_c = c;
      flag_z = z;
      step   = s;
      @(negedge clk);
      check_pc(exp, tag);
   endtask

   task automatic mexec(input logic [17:0] ins, input logic c, input logic z, input string tag);
      model_step(ins, c, z);
      apply(ins, c, z, 1'b1, m_pc, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #800000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

   initial begin
      rst    = 1'b1;
      step   = 1'b1;
      instr  = 18'h34155;
      flag_c = 1'b0;
      flag_z = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_pc(10'h000, "R1 reset");
      rst  = 1'b0;
      step = 1'b0;

      // table walk
      for (int v = 0; v < NVEC; v++) begin
         apply(VEC[v][30:13], VEC[v][12], VEC[v][11], VEC[v][10], VEC[v][9:0],
               $sformatf("R%0d vector %0d", VEC[v][34:31], v));
      end

      // R1: reset in the middle of a call clears pc, pointer and entries
      apply(18'h30222, 1'b0, 1'b0, 1'b1, 10'h222, "R6 call before reset");
      rst = 1'b1;
      apply(18'h30111, 1'b0, 1'b0, 1'b1, 10'h000, "R1 reset over call");
      rst = 1'b0;
      model_reset();

      // R8: pop from empty stack reads cleared entry 0, pointer wraps to 31
      mexec(18'h2A000, 1'b0, 1'b0, "R8 underflow pop");
      mexec(18'h30100, 1'b0, 1'b0, "R8 push after underflow");
      mexec(18'h2A000, 1'b0, 1'b0, "R8 pop after wrap");

      // R8: 33 nested calls overwrite the oldest entry
      for (int k = 0; k < 33; k++) begin
         mexec(18'h30000 | 18'(10'h040 + 10'(k * 5)), 1'b0, 1'b0, "R8 nested call");
         mexec(18'h00000, 1'b0, 1'b0, "R3 between calls");
      end
      for (int k = 0; k < 33; k++) begin
         mexec(18'h2A000, 1'b0, 1'b0, "R8 nested return");
      end

      // R5/R7: every condition of the conditional return
      for (int cs = 0; cs < 4; cs++) begin
         mexec(18'h30080, 1'b0, 1'b0, "R6 call for conditional return");
         mexec(18'h2B000 | 18'(cs << 10), 1'b1, 1'b1, "R5 conditional return flags 11");
         mexec(18'h2B000 | 18'(cs << 10), 1'b0, 1'b0, "R5 conditional return flags 00");
         mexec(18'h2A000, 1'b0, 1'b0, "R7 cleanup return");
      end

      // R2: no step with a return pending leaves pc, then the return uses the intact stack
      mexec(18'h30333, 1'b0, 1'b0, "R6 call before hold");
      apply(18'h2A000, 1'b0, 1'b0, 1'b0, m_pc, "R2 return without step");
      apply(18'h2A000, 1'b0, 1'b0, 1'b0, m_pc, "R2 return without step again");
      mexec(18'h2A000, 1'b0, 1'b0, "R7 return after hold");

      finish_run();
   end

endmodule